// File: doc/BRIEF.md
# Flag-Aware Barrel Rotator

This combinational datapath block rotates a 64-bit operand in one evaluation. It offers four operations: plain rotate left, plain rotate right, and rotate left or right with the carry flag placed inside the ring. The operand width is selectable as 8, 16, 32 or 64 bits. The result appears in the low bits for that width, and every bit above it reads as zero.

The block takes an 8-bit raw count and reduces it to a per-width effective distance. Alongside the rotated value it returns the next carry and overflow flag values and a write strobe for each flag. The strobes follow exact count rules, so the surrounding register file only updates a flag when the rotate defines it. Whenever a strobe is low, the matching flag output passes the incoming flag through unchanged.

Top module: `rot_flag_unit`

## Requirements
- R1: The raw count is ANDed with 0x1F for widths 8, 16 and 32, and with 0x3F for width 64, giving the masked count. Width select: 00=8, 01=16, 10=32, 11=64.
- R2: Operation select is 00 plain left, 01 plain right, 10 left through carry, 11 right through carry. A plain rotate turns the sized operand by the masked count modulo the width.
- R3: A through-carry rotate turns a ring of width+1 bits, with the carry above the operand MSB. The distance is the masked count modulo 9 at width 8 and modulo 17 at width 16, with no reduction at 32 and 64.
- R4: With a masked count of zero, the result is the sized operand, both strobes are low, and both flag outputs equal the incoming flags.
- R5: For a plain rotate with a nonzero masked count, the carry strobe is high. The new carry is the result LSB after a left rotate and the result MSB after a right rotate.
- R6: For a through-carry rotate with a nonzero masked count, the carry strobe is high and the new carry is the ring bit that ends in the carry position. A full-ring distance returns the incoming carry.
- R7: When the masked count equals 1, the overflow strobe is high and the overflow output takes an operation-dependent value. For both left forms it is result MSB XOR new carry. For right through carry it is operand MSB XOR incoming carry. For plain right it is result MSB XOR the bit below it.
- R8: When the masked count exceeds 1, the overflow strobe is low and the overflow output equals the incoming overflow. This holds even when the reduced distance is 1, for example width 8, left through carry, count 10.
- R9: Result bits at and above the selected width are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd | input | 64 | Operand; only the low bits of the selected width are used |
| cnt | input | 8 | Raw rotate count |
| size_sel | input | 2 | Width select |
| op_sel | input | 2 | Operation select |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| res | output | 64 | Rotated value, zero above the width |
| cf_out | output | 1 | Next carry flag |
| of_out | output | 1 | Next overflow flag |
| cf_we | output | 1 | Carry write strobe |
| of_we | output | 1 | Overflow write strobe |

## Verification
The in-line assertions check several properties on every input change:
- the upper bits stay zero;
- a zero masked count leaves everything untouched;
- a plain rotate preserves the operand's population count;
- a through-carry rotate preserves the population count of the operand and carry together;
- the single-step relations hold for left through carry and plain right.

Only the bench's comparisons against a bit-serial reference model can show the exact bit positions for each reduced distance. The same holds for the modulo-9 and modulo-17 wrap points and for the overflow values of every operation.

// File: rtl/rot_flag_unit.sv
`timescale 1ns/1ps
module rot_flag_unit #(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic [DW-1:0] opnd,
  input  logic [CW-1:0] cnt,
  input  logic [1:0]    size_sel,
  input  logic [1:0]    op_sel,
  input  logic          cf_in,
  input  logic          of_in,
  output logic [DW-1:0] res,
  output logic          cf_out,
  output logic          of_out,
  output logic          cf_we,
  output logic          of_we
);
  localparam int RW = DW + 1;

  logic [7:0]    w, n, k;
  logic [CW-1:0] mcnt;
  logic [DW-1:0] wmask, opw, top, rotd;
  logic [RW-1:0] ring, nmask, rl, rr, rot;
  logic          thru, left, zero, rcar, rmsb, rmsb2, omsb;
  logic          cf_new, of_new;

  always_comb begin
    case (size_sel)
      2'b00:   w = 8'd8;
      2'b01:   w = 8'd16;
      2'b10:   w = 8'd32;
      default: w = 8'd64;
    endcase
  end

  assign thru  = op_sel[1];
  assign left  = ~op_sel[0];
  assign mcnt  = cnt & ((size_sel == 2'b11) ? CW'(8'h3F) : CW'(8'h1F));
  assign zero  = (mcnt == '0);
  assign wmask = {DW{1'b1}} >> (DW - 32'(w));
  assign opw   = opnd & wmask;
  assign top   = {{(DW-1){1'b0}}, 1'b1} << (w - 8'd1);
  assign n     = w + {7'd0, thru};

  always_comb begin
    if (!thru)            k = 8'(mcnt) & (w - 8'd1);
    else if (size_sel == 2'b00) k = 8'(mcnt) % 8'd9;
    else if (size_sel == 2'b01) k = 8'(mcnt) % 8'd17;
    else                  k = 8'(mcnt);
  end

  assign ring  = {1'b0, opw} | ({{DW{1'b0}}, thru & cf_in} << w);
  assign nmask = {RW{1'b1}} >> (8'(RW) - n);
  assign rl    = (ring << k) | (ring >> (n - k));
  assign rr    = (ring >> k) | (ring << (n - k));
  assign rot   = (left ? rl : rr) & nmask;
  assign rotd  = rot[DW-1:0] & wmask;
  assign rcar  = |(rot & ({{DW{1'b0}}, 1'b1} << w));

  assign rmsb  = |(rotd & top);
  assign rmsb2 = |(rotd & (top >> 1));
  assign omsb  = |(opw & top);

  assign cf_new = thru ? rcar : (left ? rotd[0] : rmsb);

  always_comb begin
    case (op_sel)
      2'b01:   of_new = rmsb ^ rmsb2;
      2'b11:   of_new = omsb ^ cf_in;
      default: of_new = rmsb ^ cf_new;
    endcase
  end

  assign res    = zero ? opw : rotd;
  assign cf_we  = ~zero;
  assign of_we  = (mcnt == CW'(1));
  assign cf_out = cf_we ? cf_new : cf_in;
  assign of_out = of_we ? of_new : of_in;

  always_comb begin
    assert_upper_zero_R9: assert ((res & ~wmask) == '0)
      else $error("upper bits set");
    assert_idle_hold_R4: assert (cf_we || (res == opw && cf_out == cf_in && of_out == of_in && !of_we))
      else $error("zero count changed state");
    assert_of_needs_cf_R7: assert (!of_we || cf_we)
      else $error("overflow strobe without carry strobe");
    assert_plain_ones_R2: assert (thru || $countones(res) == $countones(opw))
      else $error("plain rotate lost bits");
    assert_ring_ones_R3: assert (!thru || !cf_we ||
        ($countones(res) + 32'(cf_out)) == ($countones(opw) + 32'(cf_in)))
      else $error("carry ring lost bits");
    assert_rcl_step_R6: assert (!(of_we && op_sel == 2'b10) || (cf_out == omsb && res[0] == cf_in))
      else $error("single left-through-carry step wrong");
    assert_ror_step_R5: assert (!(of_we && op_sel == 2'b01) || rmsb == opw[0])
      else $error("single plain right step wrong");
  end
endmodule

// File: tb/sim_rot_flag_unit.sv
`timescale 1ns/1ps
module sim_rot_flag_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] opnd, res;
  logic [7:0]  cnt;
  logic [1:0]  size_sel, op_sel;
  logic        cf_in, of_in, cf_out, of_out, cf_we, of_we;
  int total = 0, bad = 0;

  rot_flag_unit u0 (.opnd(opnd), .cnt(cnt), .size_sel(size_sel), .op_sel(op_sel),
    .cf_in(cf_in), .of_in(of_in), .res(res), .cf_out(cf_out), .of_out(of_out),
    .cf_we(cf_we), .of_we(of_we));

  function automatic logic [67:0] model(input logic [1:0] op, input logic [1:0] sz,
      input logic [63:0] v, input logic [7:0] c, input logic cf, input logic of);
    int wd, mk, st;
    logic [63:0] m, d;
    logic b, cc, oo, m0;
    wd = 8 << sz;
    m  = (wd == 64) ? '1 : ((64'd1 << wd) - 64'd1);
    mk = (sz == 2'b11) ? int'(c & 8'h3F) : int'(c & 8'h1F);
    d  = v & m;
    if (mk == 0) return {d, cf, of, 2'b00};
    if (!op[1]) st = mk % wd;
    else if (sz == 2'b00) st = mk % 9;
    else if (sz == 2'b01) st = mk % 17;
    else st = mk;
    cc = cf;
    m0 = d[wd-1];
    for (int i = 0; i < st; i++) begin
      case (op)
        2'b00: begin b = d[wd-1]; d = ((d << 1) | 64'(b)) & m; end
        2'b01: begin b = d[0]; d = (d >> 1) | (64'(b) << (wd-1)); end
        2'b10: begin b = d[wd-1]; d = ((d << 1) | 64'(cc)) & m; cc = b; end
        default: begin b = d[0]; d = (d >> 1) | (64'(cc) << (wd-1)); cc = b; end
      endcase
    end
    if (op == 2'b00) cc = d[0];
    if (op == 2'b01) cc = d[wd-1];
    if (mk == 1) begin
      case (op)
        2'b01:   oo = d[wd-1] ^ d[wd-2];
        2'b11:   oo = m0 ^ cf;
        default: oo = d[wd-1] ^ cc;
      endcase
      return {d, cc, oo, 2'b11};
    end
    return {d, cc, of, 2'b10};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (op=%b sz=%b cnt=%0d v=%h cf=%b of=%b)",
               tag, act, exp, op_sel, size_sel, cnt, opnd, cf_in, of_in);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [1:0] sz, input logic [63:0] v,
      input logic [7:0] c, input logic cf, input logic of, input string pre);
    logic [67:0] e;
    int mk;
    @(negedge clk);
    op_sel = op; size_sel = sz; opnd = v; cnt = c; cf_in = cf; of_in = of;
    #1;
    e  = model(op, sz, v, c, cf, of);
    mk = (sz == 2'b11) ? int'(c & 8'h3F) : int'(c & 8'h1F);
    chk({pre, (mk == 0) ? "R4 res" : (op[1] ? "R3 res" : "R2 res")}, res, e[67:4]);
    chk({pre, "R9 upper"}, res >> (8 << sz), 64'd0);
    chk({pre, (mk == 0) ? "R4 cf" : (op[1] ? "R6 cf" : "R5 cf")}, 64'(cf_out), 64'(e[3]));
    chk({pre, (mk == 0) ? "R4 of" : ((mk == 1) ? "R7 of" : "R8 of")}, 64'(of_out), 64'(e[2]));
    chk({pre, (mk == 0) ? "R4 strobes" : ((mk == 1) ? "R7 strobes" : "R8 strobes")},
        64'({cf_we, of_we}), 64'(e[1:0]));
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    opnd = '0; cnt = '0; size_sel = '0; op_sel = '0; cf_in = 0; of_in = 0;
    #1;
    chk("R4 initial res", res, 64'd0);
    chk("R4 initial strobes", 64'({cf_we, of_we}), 64'd0);
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++) begin
        int wd = 8 << s;
        apply(2'(o), 2'(s), 64'hF0E1_D2C3_B4A5_9687, 8'd0, 1'b1, 1'b0, "corner ");
        apply(2'(o), 2'(s), 64'h8000_0001_8000_0081, 8'd1, 1'b1, 1'b1, "corner ");
        apply(2'(o), 2'(s), 64'hA5A5_5A5A_C3C3_3C3C, 8'(wd), 1'b0, 1'b1, "corner ");
        apply(2'(o), 2'(s), 64'h1234_5678_9ABC_DEF0, 8'(wd + 1), 1'b1, 1'b0, "corner ");
      end
    apply(2'b00, 2'b00, 64'h0000_0000_0000_0096, 8'h20, 1'b1, 1'b1, "R1 mask8 ");
    apply(2'b01, 2'b11, 64'hDEAD_BEEF_0BAD_F00D, 8'h40, 1'b0, 1'b1, "R1 mask64 ");
    apply(2'b10, 2'b11, 64'h8000_0000_0000_0000, 8'h41, 1'b0, 1'b0, "R1 mask64one ");
    apply(2'b11, 2'b01, 64'h0000_0000_0000_8001, 8'h25, 1'b1, 1'b0, "R1 mask16 ");
    apply(2'b10, 2'b00, 64'h0000_0000_0000_0081, 8'd10, 1'b0, 1'b1, "R8 rcl8c10 ");
    apply(2'b10, 2'b00, 64'h0000_0000_0000_0081, 8'd10, 1'b1, 1'b0, "R8 rcl8c10 ");
    apply(2'b11, 2'b00, 64'h0000_0000_0000_005A, 8'd9, 1'b1, 1'b0, "R6 fullring9 ");
    apply(2'b10, 2'b01, 64'h0000_0000_0000_F00F, 8'd17, 1'b0, 1'b0, "R6 fullring17 ");
    apply(2'b11, 2'b10, 64'h0000_0000_8000_0001, 8'd31, 1'b1, 1'b1, "R3 rcr32c31 ");
    apply(2'b10, 2'b11, 64'hFFFF_0000_FFFF_0000, 8'd63, 1'b0, 1'b0, "R3 rcl64c63 ");
    for (int i = 0; i < 3000; i++)
      apply(2'($urandom), 2'($urandom), {$urandom, $urandom}, 8'($urandom),
            1'($urandom), 1'($urandom), "rand ");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule